// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside an AHB memory subordinate and watches every transfer the subordinate accepts. It lets a manager carry out a read-modify-write as a reservation pair. An exclusive read inside the supported address window takes a reservation. A later exclusive write from the same manager succeeds only if that reservation is still intact and every attribute of the write equals the attribute recorded at the read. The block tells the memory whether to store the write data, and it returns the exclusive-okay response to the requester.

There is one reservation slot for each exclusive-capable manager. A manager identity selects its slot by taking the identity modulo the slot count. The success or failure of an exclusive transfer is decided in its address phase, against the slot state as it stands after every earlier accepted transfer. The result is registered into the data phase. There, the write-enable qualifies the memory write, and the response is shown on the completing cycle.

Top module: `exmon_top`

## Requirements
- R1: An accepted exclusive read whose address lies in [WIN_BASE, WIN_LIMIT] records address, size, protection, burst, secure attribute and full manager identity in slot (master_i mod N_MGR), and exokay_o is high on the completing data-phase cycle of that read.
- R2: There are N_MGR independent slots. Managers that map to different slots do not disturb each other's reservations. A new exclusive read replaces whatever the slot held, including a reservation from an aliased identity.
- R3: An exclusive write succeeds (exokay_o high, mem_we_o high) only when its slot is valid and addr_i, size_i, prot_i, burst_i, nonsec_i and the full master_i equal the recorded values, and the address lies in the window.
- R4: An effective write (a non-exclusive write, or a successful exclusive write) by any other identity whose byte range [addr, addr+2^size-1] overlaps a reserved byte range clears that reservation.
- R5: A failed exclusive write, including one with no earlier exclusive read, keeps mem_we_o low and exokay_o low through its data phase.
- R6: Non-exclusive transfers leave reservations intact except as in R4. Non-exclusive reads never clear a slot, and a manager's own non-exclusive write never clears its own slot. A non-exclusive write always gets mem_we_o high.
- R7: exokay_o is high only in the data phase of an exclusive transfer, only while ready_i is high, and never while err_i is high.
- R8: An exclusive read or write outside the window fails (exokay_o low), takes no reservation and produces no memory write.
- R9: A successful exclusive write clears its own slot, so an identical second exclusive write fails.
- R10: After synchronous reset all slots are empty and both outputs are low.
- R11: mem_we_o is a register. It is set for the whole data phase of an accepted permitted write, including wait states with ready_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trans_i | input | 1 | Address phase holds a real transfer |
| addr_i | input | ADDR_W | Transfer byte address |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | Transfer size, 2^size bytes |
| burst_i | input | 3 | Burst type attribute |
| prot_i | input | 4 | Protection attribute |
| nonsec_i | input | 1 | Non-secure attribute |
| master_i | input | MST_W | Requesting manager identity |
| excl_i | input | 1 | Transfer is exclusive |
| ready_i | input | 1 | Transfer-done handshake of the bus |
| err_i | input | 1 | Subordinate returns an error in this data-phase cycle |
| mem_we_o | output | 1 | Write permitted for the current data phase |
| exokay_o | output | 1 | Exclusive transfer succeeded |

## Verification
A slot that is wrongly kept, lost or overwritten shows up only on a later exclusive write. That write reports the wrong exokay_o and the wrong mem_we_o one cycle after its address phase is accepted, which may be many transfers after the fault. The bench therefore runs a behavioural reservation model beside the design and compares both outputs on every cycle. The stimulus reuses a small set of overlapping addresses, aliased manager identities, wait states and error cycles, so that a corrupted slot is exposed within a few transfers. Directed sequences pin down each clearing rule on its own.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
  // Attributes that must be identical between the reserving read and the write
  typedef struct packed {
    logic [2:0] size;
    logic [3:0] prot;
    logic [2:0] burst;
    logic       nonsec;
  } xattr_t;
endpackage

// File: rtl/exmon_window.sv
module exmon_window #(
  parameter int               AW    = 32,
  parameter logic [AW-1:0]    BASE  = '0,
  parameter logic [AW-1:0]    LIMIT = '1
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_o
);
  localparam logic [AW-1:0] SPAN = LIMIT - BASE;

  // one unsigned compare of the offset covers both bounds
  assign in_o = (addr_i - BASE) <= SPAN;
endmodule

// File: rtl/exmon_slots.sv
module exmon_slots
  import exmon_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_i,
  input  logic          write_i,
  input  logic          excl_i,
  input  logic          in_win_i,
  input  logic [AW-1:0] addr_i,
  input  xattr_t        attr_i,
  input  logic [MW-1:0] master_i,
  output logic          ok_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int RW = AW + 1;

  function automatic logic [RW-1:0] span_end(logic [AW-1:0] a, logic [2:0] sz);
    return {1'b0, a} + (RW'(1) << sz) - RW'(1);
  endfunction

  logic [IW-1:0] idx;
  logic [N-1:0]  vld_q, vld_d, ovl, other;
  logic [AW-1:0] addr_q [N];
  xattr_t        attr_q [N];
  logic [MW-1:0] mst_q  [N];
  logic          match, eff_wr, take;
  logic [RW-1:0] req_lo, req_hi;

  assign idx    = IW'(master_i % MW'(N));
  assign req_lo = {1'b0, addr_i};
  assign req_hi = span_end(addr_i, attr_i.size);
  assign match  = vld_q[idx] && (addr_q[idx] == addr_i) &&
                  (attr_q[idx] == attr_i) && (mst_q[idx] == master_i);
  assign ok_o   = in_win_i && (!write_i || match);
  assign eff_wr = write_i && (!excl_i || ok_o);
  assign take   = acc_i && excl_i && !write_i && in_win_i;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [RW-1:0] s_lo, s_hi;
    assign s_lo     = {1'b0, addr_q[g]};
    assign s_hi     = span_end(addr_q[g], attr_q[g].size);
    assign ovl[g]   = (req_lo <= s_hi) && (s_lo <= req_hi);
    assign other[g] = mst_q[g] != master_i;
  end

  always_comb begin
    vld_d = vld_q;
    if (acc_i) begin
      for (int g = 0; g < N; g++) begin
        if (g == int'(idx) && excl_i && in_win_i) begin
          if (!write_i)  vld_d[g] = 1'b1;
          else if (ok_o) vld_d[g] = 1'b0;
        end else if (eff_wr && other[g] && ovl[g]) begin
          vld_d[g] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= vld_d;
  end

  // slot payload: written by index, no reset, RAM friendly
  always_ff @(posedge clk) begin
    if (take) begin
      addr_q[idx] <= addr_i;
      attr_q[idx] <= attr_i;
      mst_q[idx]  <= master_i;
    end
  end

  AST_READ_TAKES_SLOT: assert property (@(posedge clk) disable iff (rst)
    take |=> vld_q[$past(idx)]); // R1
  AST_SUCCESS_FREES_SLOT: assert property (@(posedge clk) disable iff (rst)
    acc_i && excl_i && write_i && ok_o |=> !vld_q[$past(idx)]); // R9
endmodule

// File: rtl/exmon_resp.sv
module exmon_resp (
  input  logic clk,
  input  logic rst,
  input  logic ready_i,
  input  logic err_i,
  input  logic acc_i,
  input  logic excl_i,
  input  logic ok_i,
  input  logic we_i,
  output logic mem_we_o,
  output logic exokay_o
);
  logic dv_q, dex_q, dok_q, dwe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q  <= 1'b0;
      dex_q <= 1'b0;
      dok_q <= 1'b0;
      dwe_q <= 1'b0;
    end else if (ready_i) begin
      dv_q  <= acc_i;
      dex_q <= acc_i && excl_i;
      dok_q <= ok_i;
      dwe_q <= acc_i && we_i;
    end
  end

  assign mem_we_o = dwe_q;
  assign exokay_o = dex_q && dok_q && ready_i && !err_i;

  AST_OKAY_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
    exokay_o |-> dv_q); // R7
  AST_WE_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    dv_q && !ready_i |=> $stable(mem_we_o)); // R11
endmodule

// File: rtl/exmon_top.sv
module exmon_top
  import exmon_pkg::*;
#(
  parameter int                 N_MGR     = 4,
  parameter int                 MST_W     = 8,
  parameter int                 ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE  = '0,
  parameter logic [ADDR_W-1:0]  WIN_LIMIT = ADDR_W'(32'h0000_FFFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        burst_i,
  input  logic [3:0]        prot_i,
  input  logic              nonsec_i,
  input  logic [MST_W-1:0]  master_i,
  input  logic              excl_i,
  input  logic              ready_i,
  input  logic              err_i,
  output logic              mem_we_o,
  output logic              exokay_o
);
  logic   acc, in_win, slot_ok, allow;
  xattr_t attr;

  assign acc   = trans_i && ready_i;
  assign attr  = '{size: size_i, prot: prot_i, burst: burst_i, nonsec: nonsec_i};
  assign allow = write_i && (!excl_i || slot_ok);

  exmon_window #(.AW(ADDR_W), .BASE(WIN_BASE), .LIMIT(WIN_LIMIT)) u_win (
    .addr_i (addr_i),
    .in_o   (in_win)
  );

  exmon_slots #(.N(N_MGR), .AW(ADDR_W), .MW(MST_W)) u_slots (
    .clk      (clk),
    .rst      (rst),
    .acc_i    (acc),
    .write_i  (write_i),
    .excl_i   (excl_i),
    .in_win_i (in_win),
    .addr_i   (addr_i),
    .attr_i   (attr),
    .master_i (master_i),
    .ok_o     (slot_ok)
  );

  exmon_resp u_resp (
    .clk      (clk),
    .rst      (rst),
    .ready_i  (ready_i),
    .err_i    (err_i),
    .acc_i    (acc),
    .excl_i   (excl_i),
    .ok_i     (slot_ok),
    .we_i     (allow),
    .mem_we_o (mem_we_o),
    .exokay_o (exokay_o)
  );

  AST_OUTSIDE_WINDOW_FAILS: assert property (@(posedge clk) disable iff (rst)
    acc && excl_i && !in_win |-> !slot_ok); // R8
  AST_FAILED_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    acc && excl_i && write_i && !slot_ok |=> !mem_we_o && !exokay_o); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !mem_we_o && !exokay_o); // R10
endmodule

// File: tb/exmon_top_tb.sv
`timescale 1ns/1ps
module exmon_top_tb;
  localparam int N = 4;
  localparam longint LIM = 64'h0000_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic trans_i = 0, write_i = 0, nonsec_i = 0, excl_i = 0, ready_i = 1, err_i = 0;
  logic [31:0] addr_i = '0;
  logic [2:0]  size_i = '0, burst_i = '0;
  logic [3:0]  prot_i = '0;
  logic [7:0]  master_i = '0;
  logic mem_we_o, exokay_o;

  always #2.5 clk = ~clk;

  exmon_top u_dut (.*);

  int errors = 0, checks = 0;
  logic last_we, last_ok;

  // behavioural reservation model
  bit          m_v [N];
  longint      m_a [N];
  int          m_sz[N], m_pr[N], m_bu[N], m_ns[N], m_ms[N];
  bit d_ex = 0, d_ok = 0, d_we = 0;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cyc(input bit tr, input longint a, input bit wr, input int sz,
                     input int bu, input int pr, input bit ns, input int ms,
                     input bit ex, input bit rdy, input bit er);
    bit inw, hit, mok, eff;
    int i;
    trans_i = tr; addr_i = a[31:0]; write_i = wr; size_i = sz[2:0]; burst_i = bu[2:0];
    prot_i = pr[3:0]; nonsec_i = ns; master_i = ms[7:0]; excl_i = ex;
    ready_i = rdy; err_i = er;
    #1;
    last_we = mem_we_o; last_ok = exokay_o;
    chk(mem_we_o, d_we, d_ex ? "R5" : "R6");
    chk(exokay_o, d_ex && d_ok && rdy && !er, !d_ex ? "R7" : "R3");
    if (rdy) begin
      i   = ms % N;
      inw = a <= LIM;
      hit = m_v[i] && m_a[i] == a && m_sz[i] == sz && m_pr[i] == pr &&
            m_bu[i] == bu && m_ns[i] == int'(ns) && m_ms[i] == ms;
      mok = inw && (!wr || hit);
      eff = wr && (!ex || mok);
      d_ex = tr && ex; d_ok = mok; d_we = tr && eff;
      if (tr) begin
        for (int j = 0; j < N; j++) begin
          if (j == i && ex && inw) begin
            if (!wr) begin
              m_v[j] = 1; m_a[j] = a; m_sz[j] = sz; m_pr[j] = pr;
              m_bu[j] = bu; m_ns[j] = int'(ns); m_ms[j] = ms;
            end else if (mok) m_v[j] = 0;
          end else if (eff && m_v[j] && m_ms[j] != ms &&
                       a <= m_a[j] + (64'd1 << m_sz[j]) - 1 &&
                       m_a[j] <= a + (64'd1 << sz) - 1) begin
            m_v[j] = 0;
          end
        end
      end
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic xr(input int ms, input longint a, input int pr);
    cyc(1, a, 0, 2, 1, pr, 0, ms, 1, 1, 0);
  endtask
  task automatic xw(input int ms, input longint a, input int pr);
    cyc(1, a, 1, 2, 1, pr, 0, ms, 1, 1, 0);
  endtask
  task automatic nw(input int ms, input longint a, input int sz);
    cyc(1, a, 1, sz, 1, 3, 0, ms, 0, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int ms, ai, sz, pr;
    bit ex, wr;
    longint addrs [5] = '{64'h100, 64'h102, 64'h104, 64'h108, 64'h20000};
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: empty after reset
    idle(); chk(last_we, 0, "R10"); chk(last_ok, 0, "R10");
    xw(1, 'h100, 3); idle(); chk(last_ok, 0, "R10"); chk(last_we, 0, "R5");
    // R1, R3, R9
    xr(1, 'h100, 3); idle(); chk(last_ok, 1, "R1");
    xw(1, 'h100, 3); idle(); chk(last_ok, 1, "R3"); chk(last_we, 1, "R3");
    xw(1, 'h100, 3); idle(); chk(last_ok, 0, "R9"); chk(last_we, 0, "R9");
    // R4: other identity byte write overlapping
    xr(1, 'h100, 3); nw(2, 'h102, 0); xw(1, 'h100, 3); idle();
    chk(last_ok, 0, "R4"); chk(last_we, 0, "R4");
    // R6: reads, own write, far write keep reservation
    xr(1, 'h100, 3); cyc(1, 'h100, 0, 2, 1, 3, 0, 2, 0, 1, 0);
    nw(1, 'h100, 2); chk(last_we, 0, "R6"); idle(); chk(last_we, 1, "R6");
    nw(2, 'h200, 2);
    xw(1, 'h100, 3); idle(); chk(last_ok, 1, "R6");
    // R3: attribute mismatch
    xr(1, 'h104, 3); xw(1, 'h104, 2); idle(); chk(last_ok, 0, "R3");
    // R8: outside window
    xr(3, 'h20000, 3); idle(); chk(last_ok, 0, "R8");
    xw(3, 'h20000, 3); idle(); chk(last_we, 0, "R8");
    // R2: aliasing identity replaces slot; distinct slots independent
    xr(1, 'h100, 3); xr(5, 'h108, 3); xw(1, 'h100, 3); idle(); chk(last_ok, 0, "R2");
    xr(2, 'h100, 3); xr(3, 'h104, 3); xw(2, 'h100, 3); xw(3, 'h104, 3);
    chk(last_ok, 1, "R2"); idle(); chk(last_ok, 1, "R2");
    // R7: error and non-exclusive get no okay
    xr(1, 'h100, 3); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1); chk(last_ok, 0, "R7");
    cyc(1, 'h100, 0, 2, 1, 3, 0, 1, 0, 1, 0); idle(); chk(last_ok, 0, "R7");
    // R11: wait state keeps write enable, okay only on completion
    xr(1, 'h100, 3); xw(1, 'h100, 3);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk(last_we, 1, "R11"); chk(last_ok, 0, "R7");
    idle(); chk(last_we, 1, "R11"); chk(last_ok, 1, "R11");
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      ms = $urandom_range(0, 7); ai = $urandom_range(0, 4);
      sz = $urandom_range(0, 2); pr = $urandom_range(2, 3);
      ex = $urandom_range(0, 1); wr = $urandom_range(0, 1);
      if (ex && wr && m_v[ms % N] && $urandom_range(0, 9) < 7)
        cyc(1, m_a[ms % N], 1, m_sz[ms % N], m_bu[ms % N], m_pr[ms % N],
            m_ns[ms % N][0], m_ms[ms % N], 1, $urandom_range(0, 3) != 0, 0);
      else
        cyc($urandom_range(0, 4) != 0, addrs[ai], wr, sz, $urandom_range(0, 1), pr,
            $urandom_range(0, 1), ms, ex, $urandom_range(0, 3) != 0,
            $urandom_range(0, 9) == 0);
    end
    summary();
  end
endmodule